// File: doc/BRIEF.md
# Write-Port Slot Booker

A pipeline whose execution units have unequal latencies still funnels every result through one shared downstream stage that takes a single instruction per cycle. This block sits in the decode stage and prevents two instructions from arriving at that stage in the same cycle. It keeps a vector of booked future cycles. Each incoming instruction class is mapped to its fixed distance, in cycles, to the shared stage. The instruction is either given its slot at once or held in decode.

Each clock the vector moves one place toward the present. In a cycle, decode presents a valid flag and a class code. The block checks the slot that the class would occupy, using the vector after that cycle's move. If the slot is free, the block books it and pulses `accept`. If the slot is taken, it raises `stall`, and fetch and decode keep the same instruction. The move continues while decode is held, so the blocking booking drifts out of the checked slot and the held instruction goes through.

Top module: `resv_write_port_booker`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears every booking. The first valid instruction of any class after reset is accepted.
- R2: Class codes 0, 1, 2 and 3 have default distances of 2, 4, 7 and 25 cycles to the shared stage. An instruction of class c that is accepted in decode cycle t occupies cycle t+L(c). A later instruction is blocked only when its own arrival cycle equals an occupied cycle.
- R3: When `dec_valid` is 1 and the arrival cycle of the presented class is already occupied, `stall` is 1 and `accept` is 0 in that cycle, and no new booking is made.
- R4: When `dec_valid` is 1 and the arrival cycle is free, `accept` is 1 and `stall` is 0 in that same cycle, and the arrival cycle becomes occupied from the next cycle on.
- R5: Bookings age by one cycle on every clock, including stalled cycles. An instruction held in decode is therefore accepted within (longest distance − 1) cycles.
- R6: A cycle with `dec_valid` at 0 books nothing. A later instruction whose arrival cycle matches the class presented in the idle cycle is accepted.
- R7: `stall` and `accept` are never 1 together, and both are 0 when `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_class | input | CLS_W (2) | Latency class code of that instruction |
| stall | output | 1 | Hold fetch and decode this cycle |
| accept | output | 1 | Instruction got its slot and leaves decode |

## Verification
The assertions assume that decode holds its instruction whenever `stall` is raised. They also assume that the class code is one of the configured classes. The bench meets both conditions: it re-presents a stalled instruction unchanged until it is accepted, and it draws class codes only from 0 to 3. The assertions do not depend on reset being held for more than one edge. The stimulus still holds reset for two edges before every sweep.

// File: rtl/resv_pkg.sv
package resv_pkg;
   localparam int LAT_BITS    = 8;
   localparam int MAX_CLASSES = 16;

   typedef logic [MAX_CLASSES*LAT_BITS-1:0] lat_tbl_t;

   // largest distance among the first n table entries
   function automatic int max_lat(input lat_tbl_t tbl, input int n);
      int m;
      m = 0;
      for (int i = 0; i < n; i++) begin
         if (int'(tbl[i*LAT_BITS +: LAT_BITS]) > m) m = int'(tbl[i*LAT_BITS +: LAT_BITS]);
      end
      return m;
   endfunction

   function automatic int min_lat(input lat_tbl_t tbl, input int n);
      int m;
      m = 255;
      for (int i = 0; i < n; i++) begin
         if (int'(tbl[i*LAT_BITS +: LAT_BITS]) < m) m = int'(tbl[i*LAT_BITS +: LAT_BITS]);
      end
      return m;
   endfunction
endpackage

// File: rtl/resv_lat_decode.sv
module resv_lat_decode #(
   parameter int                 NCLS    = 4,
   parameter int                 CLS_W   = 2,
   parameter int                 IDX_W   = 5,
   parameter resv_pkg::lat_tbl_t LAT_TBL = '0
) (
   input  logic [CLS_W-1:0] cls,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] cls_idx [NCLS];

   // slot index = distance - 2 (index 0 is two cycles ahead)
   for (genvar g = 0; g < NCLS; g++) begin : g_cls
      localparam int LAT = int'(LAT_TBL[g*resv_pkg::LAT_BITS +: resv_pkg::LAT_BITS]);
      if (LAT < 2) begin : g_bad
         $error("class distance must be at least 2 cycles");
      end
      assign cls_idx[g] = IDX_W'(LAT - 2);
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < NCLS; i++) begin
         if (cls == CLS_W'(i)) idx = cls_idx[i];
      end
   end
endmodule

// File: rtl/resv_slot_vector.sv
module resv_slot_vector #(
   parameter int W     = 24,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] idx,
   input  logic             book,
   output logic             busy,
   output logic [W-1:0]     vec_q
);
   logic [W-1:0] aged;
   logic [W-1:0] book_mask;

   // aging step: every booking moves one cycle closer
   if (W == 1) begin : g_single
      assign aged = '0;
   end else begin : g_multi
      assign aged = {1'b0, vec_q[W-1:1]};
   end

   assign busy      = aged[idx];
   assign book_mask = W'(book) << idx;

   always_ff @(posedge clk) begin
      if (rst) vec_q <= '0;
      else     vec_q <= aged | book_mask;
   end
endmodule

// File: rtl/resv_write_port_booker.sv
module resv_write_port_booker #(
   parameter int                 NCLS    = 4,
   parameter resv_pkg::lat_tbl_t LAT_TBL = {96'd0, 8'd25, 8'd7, 8'd4, 8'd2},
   localparam int                CLS_W   = (NCLS > 1) ? $clog2(NCLS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dec_valid,
   input  logic [CLS_W-1:0] dec_class,
   output logic             stall,
   output logic             accept
);
   localparam int MAXL  = resv_pkg::max_lat(LAT_TBL, NCLS);
   localparam int MINL  = resv_pkg::min_lat(LAT_TBL, NCLS);
   localparam int W     = MAXL - 1;
   localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

   if (NCLS < 1 || NCLS > resv_pkg::MAX_CLASSES) begin : g_bad_ncls
      $error("NCLS out of range");
   end
   if (MINL < 2) begin : g_bad_lat
      $error("every class needs a distance of at least 2");
   end

   logic [IDX_W-1:0] slot_idx;
   logic             slot_busy;
   logic [W-1:0]     slot_vec;

   resv_lat_decode #(
      .NCLS(NCLS), .CLS_W(CLS_W), .IDX_W(IDX_W), .LAT_TBL(LAT_TBL)
   ) u_dec (
      .cls(dec_class),
      .idx(slot_idx)
   );

   resv_slot_vector #(.W(W), .IDX_W(IDX_W)) u_vec (
      .clk  (clk),
      .rst  (rst),
      .idx  (slot_idx),
      .book (accept),
      .busy (slot_busy),
      .vec_q(slot_vec)
   );

   assign stall  = dec_valid &  slot_busy;
   assign accept = dec_valid & ~slot_busy;
endmodule

// File: rtl/resv_checker.sv
module resv_checker #(
   parameter int W     = 24,
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst,
   input logic             dec_valid,
   input logic             stall,
   input logic             accept,
   input logic [IDX_W-1:0] idx,
   input logic [W-1:0]     vec_q
);
   a_r1_reset_clears: assert property (@(posedge clk) rst |=> vec_q == '0);

   a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(stall && accept));

   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !dec_valid |-> (!stall && !accept));

   a_r4_slot_booked: assert property (@(posedge clk) disable iff (rst)
      accept |=> vec_q[$past(idx)]);

   a_r3_no_booking: assert property (@(posedge clk) disable iff (rst)
      !accept |=> vec_q == ($past(vec_q) >> 1));

   a_r3_stall_needs_valid: assert property (@(posedge clk) disable iff (rst)
      stall |-> dec_valid);
endmodule

bind resv_write_port_booker resv_checker #(.W(W), .IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .dec_valid(dec_valid),
   .stall    (stall),
   .accept   (accept),
   .idx      (slot_idx),
   .vec_q    (slot_vec)
);

// File: tb/tb_resv_write_port_booker.sv
`timescale 1ns/1ps
module tb_resv_write_port_booker;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       dec_valid = 1'b0;
   logic [1:0] dec_class = '0;
   logic       stall, accept;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   logic bk [64];
   logic done = 1'b0;

   always #5 clk = ~clk;

   resv_write_port_booker dut (
      .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_class(dec_class),
      .stall(stall), .accept(accept)
   );

   function automatic int lat(input int c);
      case (c)
         0: return 2;
         1: return 4;
         2: return 7;
         default: return 25;
      endcase
   endfunction

   task automatic clear_model();
      for (int i = 0; i < 64; i++) bk[i] = 1'b0;
      cyc = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; dec_valid = 1'b0; dec_class = '0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      clear_model();
   endtask

   // one decode cycle: drive, check, update model, advance to next negedge
   task automatic step(input logic v, input int c, input string tag, output logic acc);
      logic es, ea;
      dec_valid = v; dec_class = 2'(c);
      #1;
      es = v && bk[(cyc + lat(c)) % 64];
      ea = v && !es;
      checks++;
      if (stall !== es || accept !== ea) begin
         errors++;
         $display("FAIL %s cyc %0d class %0d: stall/accept %b%b expected %b%b",
                  tag, cyc, c, stall, accept, es, ea);
      end
      acc = accept;
      if (ea) bk[(cyc + lat(c)) % 64] = 1'b1;
      bk[cyc % 64] = 1'b0;
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic note(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   initial begin
      logic a;
      do_reset();
      // R7: idle after reset is quiet
      step(1'b0, 0, "R7", a);

      // R6: idle cycle of class 1 (slot 4) books nothing; class 0 at cycle 2 hits slot 4
      do_reset();
      step(1'b0, 1, "R6", a);
      step(1'b0, 0, "R6", a);
      step(1'b1, 0, "R6", a);
      note(a === 1'b1, "R6 probe accepted", int'(a), 1);

      // pair sweep: class ca then class cb after gap k
      for (int ca = 0; ca < 4; ca++) begin
         for (int cb = 0; cb < 4; cb++) begin
            for (int k = 1; k <= 27; k++) begin
               int stalls;
               do_reset();
               step(1'b1, ca, "R1", a);
               for (int g = 1; g < k; g++) step(1'b0, 0, "R7", a);
               stalls = 0;
               a = 1'b0;
               while (!a && stalls < 30) begin
                  step(1'b1, cb, (stalls == 0) ? "R4" : "R3", a);
                  if (!a) stalls++;
               end
               // R2: blocked exactly when k + L(cb) == L(ca), for one cycle
               note(stalls == ((k + lat(cb) == lat(ca)) ? 1 : 0), "R2 stall count",
                    stalls, (k + lat(cb) == lat(ca)) ? 1 : 0);
            end
         end
      end

      // random stream, stalled instructions held; R5 bound on hold time
      do_reset();
      begin
         int c = 0;
         int held = 0;
         logic v = 1'b0;
         for (int n = 0; n < 6000; n++) begin
            if (held == 0) begin
               v = ($urandom_range(0, 9) < 8);
               c = $urandom_range(0, 3);
            end
            step(v, c, "R5", a);
            if (v && !a) held++;
            else held = 0;
            if (held > 23) begin
               note(1'b0, "R5 hold bound", held, 23);
               held = 0;
            end
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule